// File: doc/BRIEF.md
# Binary Divider Chain with Sectioned Fill Mode

This block is a chain of binary stages that divides an incoming pulse stream by a power of two. By default it has three 8-stage sections, 24 stages in all. It is modelled as a synchronous design. A system clock samples the pulse input `count_in`. A detected edge on that input acts as the enable that a ripple chain would otherwise pass from stage to stage. An active-high master reset `mr` acts at once and clears every stage, with or without a clock.

A mode machine with two named states controls how the chain advances.

- In `MODE_NORMAL`, the chain is one long counter. It advances on each falling edge of `count_in`, and the carry passes from one section into the next.
- In `MODE_TEST`, each section is a separate counter. All sections take the same pulses, and they advance on each rising edge of `count_in`.

Fill mode lets a test reach every stage in a few hundred pulses instead of millions. One transition exists in each direction:
- `MODE_NORMAL` to `MODE_TEST` when `test_mode` is sampled high.
- `MODE_TEST` to `MODE_NORMAL` when it is sampled low.

The mode state is registered. A change of `test_mode` therefore takes effect on the clock after it is sampled. The top stages drive `q_out`, and `stages` shows the whole chain.

Top module: `stage_divider`

## Requirements
- R1: In `MODE_NORMAL`, each falling edge of `count_in` adds one to `stages` as a single binary number. Carries pass across section boundaries, for example 0x0000FF becomes 0x000100.
- R2: `q_out` always equals the top `N_OUT` stages, `stages[TOTAL-1 -: N_OUT]`. With the defaults these are stages 18 to 24, with bit 0 of `q_out` being stage 18.
- R3: While `mr` is high, every stage reads 0, so `stages` and `q_out` are all zero. Stages hold 0 whatever `count_in` does.
- R4: In `MODE_TEST`, each rising edge of `count_in` adds one to every section at once. Section k occupies `stages[k*SEC_W +: SEC_W]`.
- R5: In `MODE_TEST`, a section holding all ones wraps to zero on the next pulse. No carry passes into the section above.
- R6: From reset, 2^SEC_W-1 pulses in `MODE_TEST` set every stage high (0xFFFFFF by default).
- R7: From all stages high in `MODE_NORMAL`, one falling edge returns every stage to zero.
- R8: Edges of the polarity the present mode does not use have no effect. Changing `test_mode` leaves the stored count unchanged.
- R9: In `MODE_NORMAL`, the top stage changes state once every 2^(TOTAL-1) falling edges. Its period is therefore 2^TOTAL pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples `count_in` and `test_mode` |
| mr | input | 1 | Asynchronous master reset, active high |
| count_in | input | 1 | Pulse stream to be divided |
| test_mode | input | 1 | High selects sectioned fill mode |
| q_out | output | N_OUT | Top stages of the chain |
| stages | output | SEC_W*N_SEC | Every stage of the chain |

## Verification
The properties assume that `count_in` and `test_mode` are synchronous to `clk`. They also assume that `count_in` is low when `mr` is released, so that no edge appears out of reset. The stimulus changes inputs only on the falling clock edge. It holds each level of `count_in` for a full clock period, keeps `count_in` low during and after reset, and lets two clocks pass after each change of `test_mode` before the next pulse.

// File: rtl/stage_divider_pkg.sv
package stage_divider_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_TEST   = 1'b1
    } mode_e;
endpackage

// File: rtl/sd_mode_fsm.sv
module sd_mode_fsm
    import stage_divider_pkg::*;
(
    input  logic  clk,
    input  logic  mr,
    input  logic  test_req,
    output mode_e mode
);
    mode_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_NORMAL: if (test_req)  state_nx = MODE_TEST;
            MODE_TEST:   if (!test_req) state_nx = MODE_NORMAL;
            default:     state_nx = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk or posedge mr) begin
        if (mr) state <= MODE_NORMAL;
        else    state <= state_nx;
    end

    always_comb mode = state;
endmodule

// File: rtl/sd_edge_sense.sv
module sd_edge_sense
    import stage_divider_pkg::*;
(
    input  logic  clk,
    input  logic  mr,
    input  logic  pin,
    input  mode_e mode,
    output logic  advance
);
    logic pin_q;

    always_ff @(posedge clk or posedge mr) begin
        if (mr) pin_q <= 1'b0;
        else    pin_q <= pin;
    end

    always_comb begin
        unique case (mode)
            MODE_NORMAL: advance = pin_q & ~pin;
            MODE_TEST:   advance = ~pin_q & pin;
            default:     advance = 1'b0;
        endcase
    end
endmodule

// File: rtl/sd_section.sv
module sd_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         mr,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         full
);
    always_ff @(posedge clk or posedge mr) begin
        if (mr)      cnt <= '0;
        else if (en) cnt <= cnt + 1'b1;
    end

    always_comb full = &cnt;
endmodule

// File: rtl/stage_divider.sv
module stage_divider
    import stage_divider_pkg::*;
#(
    parameter int SEC_W = 8,
    parameter int N_SEC = 3,
    parameter int N_OUT = 7
) (
    input  logic                   clk,
    input  logic                   mr,
    input  logic                   count_in,
    input  logic                   test_mode,
    output logic [N_OUT-1:0]       q_out,
    output logic [SEC_W*N_SEC-1:0] stages
);
    localparam int TOTAL = SEC_W * N_SEC;

    mode_e            mode;
    logic             advance;
    logic [N_SEC:0]   carry;
    logic [N_SEC-1:0] full;

    sd_mode_fsm u_fsm (
        .clk      (clk),
        .mr       (mr),
        .test_req (test_mode),
        .mode     (mode)
    );

    sd_edge_sense u_edge (
        .clk     (clk),
        .mr      (mr),
        .pin     (count_in),
        .mode    (mode),
        .advance (advance)
    );

    assign carry[0] = 1'b1;

    for (genvar k = 0; k < N_SEC; k++) begin : g_sec
        logic en;
        always_comb begin
            unique case (mode)
                MODE_TEST:   en = advance;
                MODE_NORMAL: en = advance & carry[k];
                default:     en = 1'b0;
            endcase
        end
        assign carry[k+1] = carry[k] & full[k];

        sd_section #(.W(SEC_W)) u_sec (
            .clk  (clk),
            .mr   (mr),
            .en   (en),
            .cnt  (stages[k*SEC_W +: SEC_W]),
            .full (full[k])
        );
    end

    assign q_out = stages[TOTAL-1 -: N_OUT];
endmodule

// File: rtl/stage_divider_chk.sv
module stage_divider_chk #(
    parameter int SEC_W = 8,
    parameter int N_SEC = 3,
    parameter int N_OUT = 7
) (
    input logic                   clk,
    input logic                   mr,
    input logic                   count_in,
    input logic                   test_mode,
    input logic [N_OUT-1:0]       q_out,
    input logic [SEC_W*N_SEC-1:0] stages
);
    localparam int TOTAL = SEC_W * N_SEC;

    logic pin_seen, tm_seen, rise, fall;

    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            pin_seen <= 1'b0;
            tm_seen  <= 1'b0;
        end else begin
            pin_seen <= count_in;
            tm_seen  <= test_mode;
        end
    end

    assign rise = count_in & ~pin_seen;
    assign fall = ~count_in & pin_seen;

    AST_RESET_CLEAR: assert property (@(posedge clk) mr |-> (stages == '0)) // R3
        else $error("reset clear");
    AST_TOP_SLICE: assert property (@(posedge clk) disable iff (mr)
        q_out == stages[TOTAL-1 -: N_OUT]) // R2
        else $error("top slice");
    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (mr)
        (!tm_seen && fall) |=> (stages == $past(stages) + 1'b1)) // R1
        else $error("normal step");
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (mr)
        !((tm_seen && rise) || (!tm_seen && fall)) |=> $stable(stages)) // R8
        else $error("idle hold");

    for (genvar k = 0; k < N_SEC; k++) begin : g_chk
        AST_SECTION_STEP: assert property (@(posedge clk) disable iff (mr)
            (tm_seen && rise) |=> (stages[k*SEC_W +: SEC_W] ==
                                   $past(stages[k*SEC_W +: SEC_W]) + 1'b1)) // R4
            else $error("section step");
    end
endmodule

bind stage_divider stage_divider_chk #(
    .SEC_W (SEC_W),
    .N_SEC (N_SEC),
    .N_OUT (N_OUT)
) u_chk (
    .clk       (clk),
    .mr        (mr),
    .count_in  (count_in),
    .test_mode (test_mode),
    .q_out     (q_out),
    .stages    (stages)
);

// File: tb/tb_stage_divider.sv
module tb_stage_divider;
    logic clk = 1'b0;
    logic mr = 1'b1;
    logic cin = 1'b0;
    logic tm = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    logic [6:0]  q_big;
    logic [23:0] st_big;
    logic [6:0]  q_sml;
    logic [8:0]  st_sml;

    always #2.5 clk = ~clk;

    stage_divider dut (
        .clk(clk), .mr(mr), .count_in(cin), .test_mode(tm),
        .q_out(q_big), .stages(st_big)
    );

    stage_divider #(.SEC_W(3), .N_SEC(3), .N_OUT(7)) dut_s (
        .clk(clk), .mr(mr), .count_in(cin), .test_mode(tm),
        .q_out(q_sml), .stages(st_sml)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) cin = 1'b1;
        @(negedge clk) cin = 1'b0;
        @(negedge clk);
    endtask

    task automatic fast_pulse();
        @(negedge clk) cin = 1'b1;
        @(negedge clk) cin = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) begin mr = 1'b1; cin = 1'b0; end
        @(negedge clk) mr = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk) tm = m;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R3: outputs low while reset is held, even with count_in toggling
        repeat (2) @(negedge clk);
        cin = 1'b1;
        @(negedge clk) cin = 1'b0;
        @(negedge clk);
        chk("R3 stages in reset", 32'(st_big), 32'h0);
        chk("R3 q_out in reset", 32'(q_big), 32'h0);
        @(negedge clk) mr = 1'b0;
        @(negedge clk);

        // R1/R9 exhaustive normal sweep; the small chain wraps at 512
        for (int k = 1; k <= 600; k++) begin
            pulse();
            chk("R1 small count", 32'(st_sml), 32'(k % 512));
            chk("R1 big count", 32'(st_big), 32'(k));
            chk("R9 small top stage", 32'(st_sml[8]), 32'((k >> 8) & 1));
            chk("R2 small q_out", 32'(q_sml), 32'((k % 512) >> 2));
        end

        // R8: a rising edge alone in normal mode does nothing
        @(negedge clk) cin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 rising ignored normal", 32'(st_big), 32'd600);
        @(negedge clk) cin = 1'b0;
        @(negedge clk);
        chk("R1 falling counts", 32'(st_big), 32'd601);

        // R8: a mode change keeps the stored count
        set_mode(1'b1);
        chk("R8 hold on enter test", 32'(st_big), 32'd601);
        set_mode(1'b0);
        chk("R8 hold on leave test", 32'(st_big), 32'd601);

        // R4/R5: sectioned counting from reset
        do_reset();
        set_mode(1'b1);
        for (int k = 1; k <= 20; k++) begin
            pulse();
            chk("R4 big sections", 32'(st_big), 32'(k * 32'h010101));
            chk("R5 small sections wrap", 32'(st_sml), 32'((k % 8) * 32'o111));
        end
        // R8: falling edge alone in test mode does nothing
        @(negedge clk) cin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 rising counts test", 32'(st_big), 32'(21 * 32'h010101));
        @(negedge clk) cin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 falling ignored test", 32'(st_big), 32'(21 * 32'h010101));

        // R6: fill to all ones in 255 pulses
        for (int k = 22; k <= 255; k++) pulse();
        chk("R6 all high", 32'(st_big), 32'hFFFFFF);
        chk("R2 q_out all high", 32'(q_big), 32'h7F);

        // R5: one more pulse wraps every section with no carry
        pulse();
        chk("R5 sections wrap", 32'(st_big), 32'h0);

        // R7: refill, leave test mode, single normal pulse rolls over
        for (int k = 1; k <= 255; k++) pulse();
        set_mode(1'b0);
        chk("R8 kept all high", 32'(st_big), 32'hFFFFFF);
        pulse();
        chk("R7 rollover", 32'(st_big), 32'h0);
        chk("R7 q_out rollover", 32'(q_big), 32'h0);

        // R9: preload 0x7F7F7F via test mode, count to top stage rise
        do_reset();
        set_mode(1'b1);
        for (int k = 1; k <= 127; k++) pulse();
        set_mode(1'b0);
        chk("R9 preload", 32'(st_big), 32'h7F7F7F);
        for (int k = 1; k < 32'h8081; k++) fast_pulse();
        @(negedge clk);
        chk("R9 top stage before", 32'(q_big[6]), 32'h0);
        chk("R1 carry chain", 32'(st_big), 32'h7FFFFF);
        pulse();
        chk("R9 top stage rises", 32'(q_big[6]), 32'h1);
        chk("R9 value at rise", 32'(st_big), 32'h800000);
        chk("R2 q_out at rise", 32'(q_big), 32'h40);

        // R3: asynchronous reset mid-run
        @(negedge clk) mr = 1'b1;
        #1;
        chk("R3 async clear", 32'(st_big), 32'h0);
        @(negedge clk) mr = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule